// File: doc/BRIEF.md
# Scaled Window Read-Address Generator

This block produces the video-memory read addresses for one display window while the raster scans. It takes its settings from a flat byte-wide control-register file, starting at a parameter-selected window base. Timing comes from a bank of raster trigger pulses: a horizontal reset, a vertical reset and a horizontal position trigger. In each pixel slot it presents a 20-bit byte address and a 32-bit command word for the memory port. The command word carries the sub-pixel X position and a window-enable flag. Alongside, it forwards a 24-bit mode/colour word to the matching pixel decoder.

Internally the block holds two pointers, both in eighth-of-a-byte units. A line pointer is reloaded from the base address on each frame reset and advances by a line stride every few lines. An X pointer starts from the line pointer at the window's left edge and advances by a zoom step every few pixels. The X pointer's high bits form the address and its three low bits form the sub-pixel position. There is no handshake: the outputs describe the current slot and are used in the same slot, with no back-pressure. All state moves only on clock edges where the pixel-phase input is zero.

Top module: `win_addr_gen`

Register offsets below are relative to the window base (WIN_BASE). Multi-byte fields put the most significant byte at the lower offset. The trigger pins are trig[H_RST_IDX] (horizontal reset), trig[H_RST_IDX+1] (vertical reset) and trig[H_POS_IDX] (horizontal position).

## Requirements
- R1: While rst_n is low and on the first cycle after it, rd_addr is 0 and cmd_out is 0.
- R2: dec_word equals {byte at +2 (foreground), byte at +1 (background), byte at +0 (mode)} at all times.
- R3: In a pixel slot with pointer value P, rd_addr = P[22:3] and cmd_out[2:0] = P[2:0]. The first slot of a line uses the line pointer. A frame reset (both reset triggers high on an enabled edge) loads the line pointer with the 24-bit base held at +3..+5.
- R4: After each slot, the X period counter is compared with the low nibble of +12. On a match, the counter returns to 0 and the pointer grows by (high nibble of +12) shifted left by mode bits [1:0]. Otherwise, the counter increments.
- R5: At the first slot of a line, the X period counter starts at the low nibble of +14.
- R6: cmd_out[7] is high for exactly W consecutive enabled slots beginning at the line start, where W is the 12-bit width {low nibble of +8, +9}. W = 0 gives no enabled slot.
- R7: On a line advance (horizontal reset alone), the Y period counter is compared with the low nibble of +13. On a match, the counter returns to 0 and the line pointer grows by the 16-bit stride at +6..+7. Otherwise, the counter increments. A frame reset preloads the Y period counter with the low nibble of +15.
- R8: After a frame reset, exactly H lines have cmd_out[7] allowed, where H is the 12-bit height {low nibble of +10, +11}.
- R9: The line starts in the slot after 1 enabled edge following the position trigger when mode bit 7 is set. Otherwise it starts after RAM_READ_CYCLES+1 enabled edges.
- R10: On edges with pix_phase nonzero, no state changes: rd_addr and cmd_out hold.
- R11: cmd_out bits [6:3] and [31:8] are always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pix_phase | input | PHASE_W | Pixel-clock phase count; updates only when zero |
| regs_flat | input | NREG*8 | Control-register file, byte i at bits [8i+7:8i] |
| trig | input | NTRIG | Raster trigger pulses |
| rd_addr | output | 20 | Video-memory byte read address |
| cmd_out | output | 32 | Sub-pixel X [2:0], window enable [7], others zero |
| dec_word | output | 24 | {foreground, background, mode} for the pixel decoder |

## Verification
A table of five X configurations walks four slots per line. It mixes unit steps, mode-scaled steps, multi-pixel periods with and without a start preload, and a sub-byte base. Together these separate errors in step scaling, period compare and preload. Directed lines then vary stride, Y period and Y preload to separate line-advance faults. They also cover width and height limits (end-of-window off-by-one), and text versus non-text trigger delay. Finally, a nonzero pixel phase must freeze the outputs mid-line.

// File: rtl/win_addr_pkg.sv
package win_addr_pkg;
  localparam int PTR_W  = 24;
  localparam int ADDR_W = 20;
  localparam int SIZE_W = 12;

  localparam int OFS_MODE = 0;
  localparam int OFS_BG   = 1;
  localparam int OFS_FG   = 2;
  localparam int OFS_BASE = 3;
  localparam int OFS_STRD = 6;
  localparam int OFS_WID  = 8;
  localparam int OFS_HGT  = 10;
  localparam int OFS_XSCL = 12;
  localparam int OFS_YSCL = 13;
  localparam int OFS_XST  = 14;
  localparam int OFS_YST  = 15;
  localparam int WIN_BYTES = 20;

  typedef struct packed {
    logic [PTR_W-1:0]  base;
    logic [15:0]       stride;
    logic [SIZE_W-1:0] width;
    logic [SIZE_W-1:0] height;
    logic [3:0]        xinc;
    logic [3:0]        xper;
    logic [3:0]        yper;
    logic [3:0]        xst;
    logic [3:0]        yst;
    logic [7:0]        mode;
    logic [23:0]       dec;
  } win_cfg_t;
endpackage

// File: rtl/wag_regmap.sv
module wag_regmap
  import win_addr_pkg::*;
#(
  parameter int NREG     = 32,
  parameter int WIN_BASE = 4
) (
  input  logic [NREG*8-1:0] regs_flat,
  output win_cfg_t          cfg
);
  function automatic logic [7:0] rb(input logic [NREG*8-1:0] f, input int ofs);
    return f[(WIN_BASE+ofs)*8 +: 8];
  endfunction

  always_comb begin
    cfg.base   = {rb(regs_flat, OFS_BASE), rb(regs_flat, OFS_BASE+1), rb(regs_flat, OFS_BASE+2)};
    cfg.stride = {rb(regs_flat, OFS_STRD), rb(regs_flat, OFS_STRD+1)};
    cfg.width  = {rb(regs_flat, OFS_WID)[3:0], rb(regs_flat, OFS_WID+1)};
    cfg.height = {rb(regs_flat, OFS_HGT)[3:0], rb(regs_flat, OFS_HGT+1)};
    cfg.xinc   = rb(regs_flat, OFS_XSCL)[7:4];
    cfg.xper   = rb(regs_flat, OFS_XSCL)[3:0];
    cfg.yper   = rb(regs_flat, OFS_YSCL)[3:0];
    cfg.xst    = rb(regs_flat, OFS_XST)[3:0];
    cfg.yst    = rb(regs_flat, OFS_YST)[3:0];
    cfg.mode   = rb(regs_flat, OFS_MODE);
    cfg.dec    = {rb(regs_flat, OFS_FG), rb(regs_flat, OFS_BG), rb(regs_flat, OFS_MODE)};
  end
endmodule

// File: rtl/wag_hdelay.sv
module wag_hdelay #(
  parameter int DEPTH = 8,
  parameter int TAP   = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ce,
  input  logic htrig,
  input  logic text_mode,
  output logic h_start
);
  logic [DEPTH-1:0] sr;

  always_ff @(posedge clk) begin
    if (!rst_n)  sr <= '0;
    else if (ce) sr <= {sr[DEPTH-2:0], htrig};
  end

  assign h_start = text_mode ? sr[0] : sr[TAP];

  // R9: first stage captures the trigger on enabled edges
  a_r9_stage0: assert property (@(posedge clk) disable iff (!rst_n)
    ce |=> sr[0] == $past(htrig));
endmodule

// File: rtl/wag_ygen.sv
module wag_ygen
  import win_addr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce,
  input  logic              frame_rst,
  input  logic              line_adv,
  input  logic [PTR_W-1:0]  base,
  input  logic [15:0]       stride,
  input  logic [SIZE_W-1:0] height,
  input  logic [3:0]        yper,
  input  logic [3:0]        yst,
  output logic [PTR_W-1:0]  line_ptr,
  output logic              run_y
);
  logic [3:0]        ycnt_per;
  logic [SIZE_W-1:0] lines;
  logic [SIZE_W:0]   lines_nxt;

  assign lines_nxt = {1'b0, lines} + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_ptr <= '0;
      ycnt_per <= '0;
      lines    <= '0;
      run_y    <= 1'b0;
    end else if (ce) begin
      if (frame_rst) begin
        line_ptr <= base;
        ycnt_per <= yst;
        lines    <= '0;
        run_y    <= (height != '0);
      end else if (line_adv) begin
        if (ycnt_per == yper) begin
          ycnt_per <= '0;
          line_ptr <= line_ptr + PTR_W'(stride);
        end else begin
          ycnt_per <= ycnt_per + 4'd1;
        end
        if (run_y) begin
          lines <= lines_nxt[SIZE_W-1:0];
          if (lines_nxt >= {1'b0, height}) run_y <= 1'b0;
        end
      end
    end
  end

  a_r3_frame_load: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && frame_rst) |=> line_ptr == $past(base));
  a_r8_height_end: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && line_adv && !frame_rst && run_y && ({1'b0, height} <= lines_nxt)) |=> !run_y);
  a_r10_yhold: assert property (@(posedge clk) disable iff (!rst_n)
    !ce |=> $stable(line_ptr) && $stable(run_y));
endmodule

// File: rtl/wag_xgen.sv
module wag_xgen
  import win_addr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce,
  input  logic              h_start,
  input  logic [PTR_W-1:0]  line_ptr,
  input  logic [SIZE_W-1:0] width,
  input  logic [3:0]        xinc,
  input  logic [3:0]        xper,
  input  logic [3:0]        xst,
  input  logic [1:0]        rate,
  output logic [PTR_W-1:0]  cur_ptr,
  output logic              en_x
);
  logic [PTR_W-1:0]  x_ptr;
  logic [3:0]        per_cnt, cur_per;
  logic [SIZE_W-1:0] pix_cnt;
  logic [SIZE_W:0]   cnt_nxt;
  logic              run_x, hit;
  logic [PTR_W-1:0]  step;

  assign cur_ptr = h_start ? line_ptr : x_ptr;
  assign cur_per = h_start ? xst : per_cnt;
  assign hit     = (cur_per == xper);
  assign step    = PTR_W'({xinc, 3'b000} >> (2'd3 - rate));
  assign cnt_nxt = h_start ? (SIZE_W+1)'(1) : ({1'b0, pix_cnt} + 1'b1);
  assign en_x    = (h_start && (width != '0)) || run_x;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      x_ptr   <= '0;
      per_cnt <= '0;
      pix_cnt <= '0;
      run_x   <= 1'b0;
    end else if (ce && (h_start || run_x)) begin
      x_ptr   <= hit ? cur_ptr + step : cur_ptr;
      per_cnt <= hit ? 4'd0 : cur_per + 4'd1;
      pix_cnt <= cnt_nxt[SIZE_W-1:0];
      run_x   <= (cnt_nxt < {1'b0, width});
    end
  end

  a_r6_single_slot: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && h_start && (width == 12'd1)) |=> !run_x);
  a_r10_xhold: assert property (@(posedge clk) disable iff (!rst_n)
    !ce |=> $stable(x_ptr) && $stable(run_x));
endmodule

// File: rtl/win_addr_gen.sv
module win_addr_gen
  import win_addr_pkg::*;
#(
  parameter int NREG            = 32,
  parameter int WIN_BASE        = 4,
  parameter int NTRIG           = 4,
  parameter int H_RST_IDX       = 0,
  parameter int H_POS_IDX       = 2,
  parameter int PHASE_W         = 4,
  parameter int DLY_DEPTH       = 8,
  parameter int RAM_READ_CYCLES = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [PHASE_W-1:0]   pix_phase,
  input  logic [NREG*8-1:0]    regs_flat,
  input  logic [NTRIG-1:0]     trig,
  output logic [ADDR_W-1:0]    rd_addr,
  output logic [31:0]          cmd_out,
  output logic [23:0]          dec_word
);
  localparam int V_RST_IDX = H_RST_IDX + 1;

  win_cfg_t         cfg;
  logic             ce, frame_rst, line_adv, h_start, run_y, en_x, win_en;
  logic [PTR_W-1:0] line_ptr, cur_ptr;

  assign ce        = (pix_phase == '0);
  assign frame_rst = trig[H_RST_IDX] && trig[V_RST_IDX];
  assign line_adv  = trig[H_RST_IDX] && !trig[V_RST_IDX];

  wag_regmap #(.NREG(NREG), .WIN_BASE(WIN_BASE)) u_map (
    .regs_flat(regs_flat), .cfg(cfg));

  wag_hdelay #(.DEPTH(DLY_DEPTH), .TAP(RAM_READ_CYCLES)) u_dly (
    .clk(clk), .rst_n(rst_n), .ce(ce), .htrig(trig[H_POS_IDX]),
    .text_mode(cfg.mode[7]), .h_start(h_start));

  wag_ygen u_y (
    .clk(clk), .rst_n(rst_n), .ce(ce), .frame_rst(frame_rst), .line_adv(line_adv),
    .base(cfg.base), .stride(cfg.stride), .height(cfg.height), .yper(cfg.yper),
    .yst(cfg.yst), .line_ptr(line_ptr), .run_y(run_y));

  wag_xgen u_x (
    .clk(clk), .rst_n(rst_n), .ce(ce), .h_start(h_start), .line_ptr(line_ptr),
    .width(cfg.width), .xinc(cfg.xinc), .xper(cfg.xper), .xst(cfg.xst),
    .rate(cfg.mode[1:0]), .cur_ptr(cur_ptr), .en_x(en_x));

  assign win_en   = en_x && run_y;
  assign rd_addr  = cur_ptr[22:3];
  assign cmd_out  = {24'd0, win_en, 4'd0, cur_ptr[2:0]};
  assign dec_word = cfg.dec;

  a_r8_no_lines: assert property (@(posedge clk) disable iff (!rst_n)
    !run_y |-> !cmd_out[7]);
  a_r11_zero_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_out[31:8] == '0) && (cmd_out[6:3] == '0));
endmodule

// File: tb/win_addr_gen_tb_top.sv
module win_addr_gen_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NREG = 32;
  localparam int B    = 4;
  localparam int NV   = 5;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [3:0]        pix_phase = '0;
  logic [NREG*8-1:0] regs_flat;
  logic [3:0]        trig = '0;
  logic [19:0]       rd_addr;
  logic [31:0]       cmd_out;
  logic [23:0]       dec_word;
  logic [7:0]        rf [NREG];
  int                n_chk = 0, n_bad = 0;
  bit                done = 0;

  // mode (text bit set), x scale byte, x start, base, expected pointer per slot
  localparam logic [7:0]  V_MODE [NV] = '{8'h80, 8'h83, 8'h80, 8'h80, 8'h82};
  localparam logic [7:0]  V_XSCL [NV] = '{8'h10, 8'h10, 8'h21, 8'h21, 8'h30};
  localparam logic [7:0]  V_XST  [NV] = '{8'h00, 8'h00, 8'h00, 8'h01, 8'h00};
  localparam logic [23:0] V_BASE [NV] = '{24'h100, 24'h100, 24'h100, 24'h100, 24'h005};
  localparam logic [23:0] V_EXP  [NV][4] = '{
    '{24'h100, 24'h101, 24'h102, 24'h103},
    '{24'h100, 24'h108, 24'h110, 24'h118},
    '{24'h100, 24'h100, 24'h102, 24'h102},
    '{24'h100, 24'h102, 24'h102, 24'h104},
    '{24'h005, 24'h011, 24'h01D, 24'h029}};

  always #(CLK_PERIOD/2) clk = ~clk;

  always_comb for (int i = 0; i < NREG; i++) regs_flat[i*8 +: 8] = rf[i];

  win_addr_gen dut_i (.clk(clk), .rst_n(rst_n), .pix_phase(pix_phase),
    .regs_flat(regs_flat), .trig(trig), .rd_addr(rd_addr), .cmd_out(cmd_out),
    .dec_word(dec_word));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk); #1;
  endtask

  task automatic setcfg(input logic [7:0] mode, input logic [23:0] base,
                        input logic [15:0] strd, input logic [11:0] w, input logic [11:0] h,
                        input logic [7:0] xs, input logic [7:0] ys, input logic [7:0] xst,
                        input logic [7:0] yst);
    rf[B+0] = mode; rf[B+1] = 8'h5A; rf[B+2] = 8'hC3;
    rf[B+3] = base[23:16]; rf[B+4] = base[15:8]; rf[B+5] = base[7:0];
    rf[B+6] = strd[15:8]; rf[B+7] = strd[7:0];
    rf[B+8] = {4'h0, w[11:8]}; rf[B+9] = w[7:0];
    rf[B+10] = {4'h0, h[11:8]}; rf[B+11] = h[7:0];
    rf[B+12] = xs; rf[B+13] = ys; rf[B+14] = xst; rf[B+15] = yst;
  endtask

  task automatic frame();  trig = 4'b0011; tick(); trig = '0; endtask
  task automatic lineadv(); trig = 4'b0001; tick(); trig = '0; endtask
  task automatic hpos();   trig = 4'b0100; tick(); trig = '0; endtask

  function automatic logic [22:0] ptr_of();
    return {rd_addr, cmd_out[2:0]};
  endfunction

  initial begin
    #(CLK_PERIOD*100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog act=hung exp=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < NREG; i++) rf[i] = 8'h00;
    @(negedge clk); tick(); #1;
    chk("R1 reset addr", 32'(rd_addr), 32'h0);
    chk("R1 reset cmd", cmd_out, 32'h0);
    rst_n = 1'b1; tick();
    chk("R1 after reset cmd", cmd_out, 32'h0);

    setcfg(8'h81, 24'h0, 16'h0, 12'd100, 12'd100, 8'h10, 8'h00, 8'h00, 8'h00); #1;
    chk("R2 decoder word", 32'(dec_word), 32'hC35A81);

    // table of X configurations
    for (int v = 0; v < NV; v++) begin
      setcfg(V_MODE[v], V_BASE[v], 16'h0, 12'd100, 12'd100, V_XSCL[v], 8'h00, V_XST[v], 8'h00);
      frame(); hpos();
      for (int s = 0; s < 4; s++) begin
        chk($sformatf("R3 R4 R5 vec%0d slot%0d", v, s), 32'(ptr_of()), 32'(V_EXP[v][s][22:0]));
        chk("R6 enable in window", 32'(cmd_out[7]), 32'h1);
        chk("R11 zero bits", {cmd_out[31:8], cmd_out[6:3]} == '0 ? 32'h0 : 32'h1, 32'h0);
        tick();
      end
    end

    // width boundary: W=3
    setcfg(8'h80, 24'h100, 16'h0, 12'd3, 12'd10, 8'h10, 8'h00, 8'h00, 8'h00);
    frame(); hpos();
    for (int s = 0; s < 4; s++) begin
      chk($sformatf("R6 width3 slot%0d", s), 32'(cmd_out[7]), s < 3 ? 32'h1 : 32'h0);
      tick();
    end
    setcfg(8'h80, 24'h100, 16'h0, 12'd0, 12'd10, 8'h10, 8'h00, 8'h00, 8'h00);
    hpos();
    chk("R6 width0", 32'(cmd_out[7]), 32'h0);

    // stride with Y period 0
    setcfg(8'h80, 24'h100, 16'h40, 12'd4, 12'd10, 8'h10, 8'h00, 8'h00, 8'h00);
    frame(); lineadv(); hpos();
    chk("R7 stride yper0", 32'(ptr_of()), 32'h140);
    // Y period 1
    setcfg(8'h80, 24'h100, 16'h40, 12'd4, 12'd10, 8'h10, 8'h01, 8'h00, 8'h00);
    frame(); lineadv(); hpos();
    chk("R7 yper1 first line", 32'(ptr_of()), 32'h100);
    lineadv(); hpos();
    chk("R7 yper1 second line", 32'(ptr_of()), 32'h140);
    // Y start preload
    setcfg(8'h80, 24'h100, 16'h40, 12'd4, 12'd10, 8'h10, 8'h01, 8'h00, 8'h01);
    frame(); lineadv(); hpos();
    chk("R7 ystart preload", 32'(ptr_of()), 32'h140);

    // height H=2
    setcfg(8'h80, 24'h100, 16'h0, 12'd2, 12'd2, 8'h10, 8'h00, 8'h00, 8'h00);
    frame(); hpos();
    chk("R8 line0", 32'(cmd_out[7]), 32'h1);
    tick(); tick(); lineadv(); hpos();
    chk("R8 line1", 32'(cmd_out[7]), 32'h1);
    tick(); tick(); lineadv(); hpos();
    chk("R8 line2 off", 32'(cmd_out[7]), 32'h0);

    // non-text trigger delay
    setcfg(8'h00, 24'h100, 16'h0, 12'd1, 12'd10, 8'h10, 8'h00, 8'h00, 8'h00);
    frame(); tick(); tick();
    hpos(); tick(); tick();
    chk("R9 not yet", 32'(cmd_out[7]), 32'h0);
    tick();
    chk("R9 delayed start", 32'(cmd_out[7]), 32'h1);
    tick();
    chk("R9 one slot", 32'(cmd_out[7]), 32'h0);

    // phase hold
    setcfg(8'h80, 24'h100, 16'h0, 12'd100, 12'd10, 8'h10, 8'h00, 8'h00, 8'h00);
    frame(); hpos();
    chk("R10 slot0", 32'(ptr_of()), 32'h100);
    pix_phase = 4'd1; tick(); tick(); tick();
    chk("R10 held", 32'(ptr_of()), 32'h100);
    chk("R10 held enable", 32'(cmd_out[7]), 32'h1);
    pix_phase = 4'd0; tick();
    chk("R10 resumes", 32'(ptr_of()), 32'h101);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule